// File: doc/BRIEF.md
# Power-Loss Cache Backup Controller

This controller keeps the contents of a volatile write cache alive across a loss of system power. While power is good it stays passive and leaves the shared memory bus released. When power fails and the host gives up the bus by taking its clock-enable low, the controller takes the bus, reads each cache word in a configured address window and streams it into non-volatile storage as a sequence of 4-bit nibbles. When power returns and a saved image is pending, it reads the nibble stream back, rebuilds each word and writes it to the same cache address. Only then does it release the bus to the host.

The cache word is 72 bits: 64 data bits and 8 check bits. All 72 bits travel through the nibble stream unchanged. A dirty flag records that flash holds an image that has not been restored yet. Busy and done outputs let the surrounding logic follow each transfer. In this model the memory port's high-impedance state is shown by an enable flag, with every driven field forced to zero while the flag is low.

Top module: `cache_guard_ctrl`

## Requirements
- R1: After a synchronous active-low reset the block is idle. `mem_oe_o`, `busy_o`, `done_o`, `dirty_o` and every strobe are low, and `mem_addr_o` is zero.
- R2: While `busy_o` is low, the memory port is released. `mem_oe_o`, `mem_rd_o` and `mem_wr_o` are low, `mem_addr_o` and `mem_wdata_o` are zero, and no flash strobe is active. This holds whatever `host_cke_i` does.
- R3: After power loss, `mem_oe_o` stays low while `host_cke_i` is high. Bus ownership begins only in the cycle after `host_cke_i` has been sampled low.
- R4: A backup reads addresses BASE to BASE+WORDS-1 in ascending order, one `mem_rd_o` cycle per word. Each word is followed by 18 `fl_wr_o` cycles that emit its nibbles from bits [3:0] upward, so bits [71:64] go out as the 17th and 18th nibbles. No other flash writes occur.
- R5: A restore reads 18 nibbles per word with `fl_rd_o`, taking `fl_din_i` in each such cycle. The first nibble becomes bits [3:0]. It then writes the rebuilt word with one `mem_wr_o` cycle to the same ascending addresses. Addresses outside the window are never written.
- R6: `dirty_o` rises in the done cycle of a backup and falls in the done cycle of a restore. A power-good period with `dirty_o` low starts no restore and produces no bus or flash activity.
- R7: If power returns during a backup, the backup still moves every word. A restore of that same image then follows automatically.
- R8: Each backup and each restore ends with `done_o` high for exactly one cycle. `busy_o` is high without a gap from the cycle after the triggering condition through that done cycle, and low in the next cycle.
- R9: `mem_oe_o` is already low in the done cycle, the cycle right after the final restore write.
- R10: While power stays bad and `dirty_o` is high, no second backup starts.
- R11: A restore also waits for `host_cke_i` low before taking the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good_i | input | 1 | System power is good |
| host_cke_i | input | 1 | Host clock-enable; high means the host drives the bus |
| mem_oe_o | output | 1 | Controller drives the memory bus (low = high impedance) |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | WORD_W | Memory write data |
| mem_rdata_i | input | WORD_W | Memory read data, valid in the read-strobe cycle |
| fl_wr_o | output | 1 | Flash nibble write strobe |
| fl_dout_o | output | NIB_W | Flash nibble to store |
| fl_rd_o | output | 1 | Flash nibble read strobe |
| fl_din_i | input | NIB_W | Flash nibble, valid in the read-strobe cycle |
| dirty_o | output | 1 | Flash holds an image not yet restored |
| busy_o | output | 1 | A backup or restore is under way |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
The hardest case to reach from the ports is power coming back while a backup is only partly done. The stimulus drops power with clock-enable already low, waits about thirty cycles so the controller is in the middle of streaming a word, and then raises power again. The scoreboard must still receive every expected nibble. It must then receive the full set of restore writes for the same image, with no help from the bench in between. A second hard case is a power-up that waits on a host that still holds clock-enable high: the bench holds the enable high for several cycles and checks that the bus stays released.

// File: rtl/cg_pkg.sv
// Shared types for the cache backup controller.
// Assumes: one state encoding shared by the sequencer and the top-level decode.
package cg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_BUS,
        ST_BK_FETCH,
        ST_BK_SEND,
        ST_RS_GATHER,
        ST_RS_STORE,
        ST_FINISH
    } cg_state_t;
endpackage

// File: rtl/cg_word_index.sv
// Word index over the protected cache window.
// Produces the absolute address BASE+index and flags the last word.
// Assumes: WORDS >= 1 and BASE+WORDS fits in ADDR_W bits.
module cg_word_index #(
    parameter int ADDR_W = 4,
    parameter int BASE   = 3,
    parameter int WORDS  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [IDX_W-1:0] idx_q;

    // Count words; restart at zero for every transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idx_q <= '0;
        end else if (advance) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Decode the final word of the window.
    assign last = (idx_q == IDX_W'(WORDS - 1));
    // Map the index onto the absolute cache address.
    assign addr = ADDR_W'(BASE) + ADDR_W'(idx_q);
endmodule

// File: rtl/cg_nibble_shifter.sv
// Word-to-nibble serialiser and nibble-to-word deserialiser sharing one register.
// Shifting out presents bits [NIB_W-1:0] first. Shifting in enters at the top, so
// the first nibble received ends in bits [NIB_W-1:0].
// Assumes: WORD_W is a multiple of NIB_W; load also restarts the nibble count.
module cg_nibble_shifter #(
    parameter int WORD_W = 72,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift_out,
    input  logic              shift_in,
    input  logic [NIB_W-1:0]  nib_in,
    output logic [WORD_W-1:0] word,
    output logic [NIB_W-1:0]  nib_out,
    output logic              last_nib
);
    localparam int NIBS  = WORD_W / NIB_W;
    localparam int CNT_W = (NIBS > 1) ? $clog2(NIBS) : 1;

    logic [WORD_W-1:0] sreg_q;
    logic [CNT_W-1:0]  cnt_q;

    // Hold, load or shift the word register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (load) begin
            sreg_q <= load_word;
        end else if (shift_out) begin
            sreg_q <= sreg_q >> NIB_W;
        end else if (shift_in) begin
            sreg_q <= {nib_in, sreg_q[WORD_W-1:NIB_W]};
        end
    end

    // Count nibbles in the current word and wrap after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            cnt_q <= '0;
        end else if (shift_out || shift_in) begin
            cnt_q <= last_nib ? '0 : cnt_q + 1'b1;
        end
    end

    assign last_nib = (cnt_q == CNT_W'(NIBS - 1));
    assign nib_out  = sreg_q[NIB_W-1:0];
    assign word     = sreg_q;
endmodule

// File: rtl/cg_seq_fsm.sv
// Transfer sequencer: decides between backup and restore and waits for the host
// to release the bus. It then steps through words and nibbles and keeps the
// dirty flag.
// Assumes: the host keeps clock-enable low for as long as the controller owns the bus.
module cg_seq_fsm (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              host_cke,
    input  logic              word_last,
    input  logic              nib_last,
    output cg_pkg::cg_state_t state,
    output logic              sh_load,
    output logic              sh_out,
    output logic              sh_in,
    output logic              idx_clear,
    output logic              idx_adv,
    output logic              dirty
);
    import cg_pkg::*;

    cg_state_t state_q, state_d;
    logic      restore_q;
    logic      dirty_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Latch the kind of transfer while idle; it is frozen once a transfer starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            restore_q <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            restore_q <= pwr_good && dirty_q;
        end
    end

    // Set the dirty flag on entering the final state of a backup; clear it for a restore.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty_q <= 1'b0;
        end else if (state_d == ST_FINISH && state_q != ST_FINISH) begin
            dirty_q <= !restore_q;
        end
    end

    // Next-state and control decode.
    always_comb begin
        state_d   = state_q;
        sh_load   = 1'b0;
        sh_out    = 1'b0;
        sh_in     = 1'b0;
        idx_clear = 1'b0;
        idx_adv   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if ((!pwr_good && !dirty_q) || (pwr_good && dirty_q)) begin
                    state_d = ST_WAIT_BUS;
                end
            end
            ST_WAIT_BUS: begin
                idx_clear = 1'b1;
                sh_load   = 1'b1;
                if (!host_cke) begin
                    state_d = restore_q ? ST_RS_GATHER : ST_BK_FETCH;
                end
            end
            ST_BK_FETCH: begin
                sh_load = 1'b1;
                state_d = ST_BK_SEND;
            end
            ST_BK_SEND: begin
                sh_out = 1'b1;
                if (nib_last) begin
                    if (word_last) begin
                        state_d = ST_FINISH;
                    end else begin
                        idx_adv = 1'b1;
                        state_d = ST_BK_FETCH;
                    end
                end
            end
            ST_RS_GATHER: begin
                sh_in = 1'b1;
                if (nib_last) begin
                    state_d = ST_RS_STORE;
                end
            end
            ST_RS_STORE: begin
                if (word_last) begin
                    state_d = ST_FINISH;
                end else begin
                    idx_adv = 1'b1;
                    state_d = ST_RS_GATHER;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign state = state_q;
    assign dirty = dirty_q;
endmodule

// File: rtl/cache_guard_ctrl.sv
// Top of the power-loss cache backup controller. Joins the sequencer, the word
// index and the nibble shifter, and gates every bus output so it reads as
// released (zero, enable low) whenever the controller does not own the bus.
// Assumes: single clock domain; a combinational memory and flash read path, valid
// in the cycle of the read strobe.
module cache_guard_ctrl #(
    parameter int ADDR_W = 4,
    parameter int WORD_W = 72,
    parameter int NIB_W  = 4,
    parameter int BASE   = 3,
    parameter int WORDS  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good_i,
    input  logic              host_cke_i,
    output logic              mem_oe_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              fl_wr_o,
    output logic [NIB_W-1:0]  fl_dout_o,
    output logic              fl_rd_o,
    input  logic [NIB_W-1:0]  fl_din_i,
    output logic              dirty_o,
    output logic              busy_o,
    output logic              done_o
);
    import cg_pkg::*;

    cg_state_t         state;
    logic              sh_load, sh_out, sh_in, idx_clear, idx_adv;
    logic              word_last, nib_last;
    logic [ADDR_W-1:0] cur_addr;
    logic [WORD_W-1:0] cur_word;
    logic [NIB_W-1:0]  cur_nib;
    logic              own_bus;

    cg_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_good  (pwr_good_i),
        .host_cke  (host_cke_i),
        .word_last (word_last),
        .nib_last  (nib_last),
        .state     (state),
        .sh_load   (sh_load),
        .sh_out    (sh_out),
        .sh_in     (sh_in),
        .idx_clear (idx_clear),
        .idx_adv   (idx_adv),
        .dirty     (dirty_o)
    );

    cg_word_index #(
        .ADDR_W (ADDR_W),
        .BASE   (BASE),
        .WORDS  (WORDS)
    ) u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (idx_clear),
        .advance (idx_adv),
        .addr    (cur_addr),
        .last    (word_last)
    );

    cg_nibble_shifter #(
        .WORD_W (WORD_W),
        .NIB_W  (NIB_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_word (mem_rdata_i),
        .shift_out (sh_out),
        .shift_in  (sh_in),
        .nib_in    (fl_din_i),
        .word      (cur_word),
        .nib_out   (cur_nib),
        .last_nib  (nib_last)
    );

    // Bus ownership covers the working states only: never idle, waiting or finishing.
    assign own_bus = (state == ST_BK_FETCH) || (state == ST_BK_SEND) ||
                     (state == ST_RS_GATHER) || (state == ST_RS_STORE);

    // Memory port with every driven field zeroed while released.
    assign mem_oe_o    = own_bus;
    assign mem_rd_o    = (state == ST_BK_FETCH);
    assign mem_wr_o    = (state == ST_RS_STORE);
    assign mem_addr_o  = own_bus  ? cur_addr : '0;
    assign mem_wdata_o = mem_wr_o ? cur_word : '0;

    // Flash nibble port.
    assign fl_wr_o   = (state == ST_BK_SEND);
    assign fl_dout_o = fl_wr_o ? cur_nib : '0;
    assign fl_rd_o   = (state == ST_RS_GATHER);

    // Status.
    assign busy_o = (state != ST_IDLE);
    assign done_o = (state == ST_FINISH);
endmodule

// File: rtl/cg_guard_checker.sv
// Protocol checker for cache_guard_ctrl, attached by bind below.
// Assumes: synchronous active-low reset; every property is disabled while reset is low.
module cg_guard_checker #(
    parameter int ADDR_W = 4,
    parameter int WORD_W = 72,
    parameter int NIB_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_cke_i,
    input logic              mem_oe_o,
    input logic              mem_rd_o,
    input logic              mem_wr_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [WORD_W-1:0] mem_wdata_o,
    input logic              fl_wr_o,
    input logic              fl_rd_o,
    input logic [NIB_W-1:0]  fl_dout_o,
    input logic              dirty_o,
    input logic              busy_o,
    input logic              done_o
);
    // Released port while idle.
    p_released_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_oe_o && !mem_rd_o && !mem_wr_o && mem_addr_o == '0 &&
                     mem_wdata_o == '0 && !fl_wr_o && !fl_rd_o && fl_dout_o == '0));

    // Ownership begins only after clock-enable was sampled low.
    p_cke_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_o) |-> !$past(host_cke_i));

    // Memory strobes only while owning the bus.
    p_strobe_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o || mem_wr_o) |-> mem_oe_o);

    // At most one transfer strobe per cycle.
    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_o, mem_wr_o, fl_wr_o, fl_rd_o}));

    // The dirty flag changes only in a done cycle.
    p_dirty_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dirty_o) |-> done_o);

    // The done pulse lasts one cycle and falls inside busy.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);
    p_busy_ends_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(done_o));

    // The bus is released exactly at the done cycle.
    p_release_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_o) |-> done_o);
endmodule

bind cache_guard_ctrl cg_guard_checker #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .NIB_W  (NIB_W)
) u_guard_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_cke_i  (host_cke_i),
    .mem_oe_o    (mem_oe_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .fl_wr_o     (fl_wr_o),
    .fl_rd_o     (fl_rd_o),
    .fl_dout_o   (fl_dout_o),
    .dirty_o     (dirty_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/test_cache_guard_ctrl.sv
// Scoreboard bench: driver tasks queue the expected flash nibbles and memory
// writes, and a negedge monitor pops and compares them as they appear.
module test_cache_guard_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 4;
    localparam int WW    = 72;
    localparam int NW    = 4;
    localparam int BASE  = 3;
    localparam int WORDS = 5;
    localparam int NIBS  = WW / NW;
    localparam int FLSZ  = WORDS * NIBS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_good = 1'b1;
    logic          host_cke = 1'b1;
    logic          mem_oe, mem_rd, mem_wr, fl_wr, fl_rd, dirty, busy, done;
    logic [AW-1:0] mem_addr;
    logic [WW-1:0] mem_wdata, mem_rdata;
    logic [NW-1:0] fl_dout, fl_din;

    logic [WW-1:0] dram [1 << AW];
    logic [NW-1:0] flash_mem [FLSZ];
    int            fl_wptr = 0;
    int            fl_rptr = 0;
    logic          ptr_clr = 1'b0;
    logic          fill_req = 1'b0;
    int            fill_seed = 0;

    logic [NW-1:0]    exp_nib_q [$];
    logic [AW+WW-1:0] exp_wr_q [$];

    int total = 0, bad = 0, mon_total = 0, mon_bad = 0, wd_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cache_guard_ctrl #(
        .ADDR_W (AW), .WORD_W (WW), .NIB_W (NW), .BASE (BASE), .WORDS (WORDS)
    ) i_cache_guard_ctrl (
        .clk (clk), .rst_n (rst_n), .pwr_good_i (pwr_good), .host_cke_i (host_cke),
        .mem_oe_o (mem_oe), .mem_rd_o (mem_rd), .mem_wr_o (mem_wr),
        .mem_addr_o (mem_addr), .mem_wdata_o (mem_wdata), .mem_rdata_i (mem_rdata),
        .fl_wr_o (fl_wr), .fl_dout_o (fl_dout), .fl_rd_o (fl_rd), .fl_din_i (fl_din),
        .dirty_o (dirty), .busy_o (busy), .done_o (done)
    );

    function automatic logic [WW-1:0] pat(input int seed, input int a);
        logic [WW-1:0] w;
        for (int k = 0; k < NIBS; k++) w[k*NW +: NW] = NW'((seed * 5 + a * 3 + k * 7 + 1) % 16);
        return w;
    endfunction

    // Combinational memory and flash read models.
    assign mem_rdata = dram[mem_addr];
    assign fl_din    = (fl_rptr < FLSZ) ? flash_mem[fl_rptr] : '0;

    // Storage models: all writes to dram and flash happen here.
    always @(posedge clk) begin
        if (fill_req) begin
            for (int a = 0; a < (1 << AW); a++) dram[a] <= pat(fill_seed, a);
        end else if (mem_wr) begin
            dram[mem_addr] <= mem_wdata;
        end
        if (ptr_clr) begin
            fl_wptr <= 0;
            fl_rptr <= 0;
        end else begin
            if (fl_rd) fl_rptr <= fl_rptr + 1;
            if (fl_wr && fl_wptr < FLSZ) begin
                flash_mem[fl_wptr] <= fl_dout;
                fl_wptr <= fl_wptr + 1;
            end
        end
    end

    task automatic mcheck(input bit ok, input string req, input string what,
                          input logic [127:0] act, input logic [127:0] exp);
        mon_total++;
        if (!ok) begin
            mon_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard queues as flash writes and memory writes appear.
    always @(negedge clk) begin
        if (rst_n) begin
            if (fl_wr) begin
                if (exp_nib_q.size() == 0) mcheck(1'b0, "R4", "unexpected flash nibble", 128'(fl_dout), 0);
                else begin
                    logic [NW-1:0] e;
                    e = exp_nib_q.pop_front();
                    mcheck(fl_dout == e, "R4", "flash nibble order", 128'(fl_dout), 128'(e));
                end
            end
            if (mem_wr) begin
                if (exp_wr_q.size() == 0) mcheck(1'b0, "R5", "unexpected memory write", 128'(mem_addr), 0);
                else begin
                    logic [AW+WW-1:0] e;
                    e = exp_wr_q.pop_front();
                    mcheck({mem_addr, mem_wdata} == e, "R5", "restore write addr/data",
                           128'({mem_addr, mem_wdata}), 128'(e));
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic fill(input int seed);
        fill_seed = seed;
        fill_req  = 1'b1;
        step();
        fill_req  = 1'b0;
    endtask

    task automatic clear_ptrs();
        ptr_clr = 1'b1;
        step();
        ptr_clr = 1'b0;
    endtask

    task automatic push_backup(input int seed);
        for (int w = 0; w < WORDS; w++) begin
            logic [WW-1:0] v;
            v = pat(seed, BASE + w);
            for (int k = 0; k < NIBS; k++) exp_nib_q.push_back(v[k*NW +: NW]);
        end
    endtask

    task automatic push_restore(input int seed);
        for (int w = 0; w < WORDS; w++) exp_wr_q.push_back({AW'(BASE + w), pat(seed, BASE + w)});
    endtask

    // Follow one transfer from busy rising to the cycle after done (R8, R9).
    task automatic run_op(input string tag);
        int n = 0;
        while (!busy && n < 50) begin step(); n++; end
        check(busy == 1'b1, "R8", {tag, " busy raised"}, 128'(busy), 1);
        n = 0;
        while (!done && n < 2000) begin
            check(busy == 1'b1, "R8", {tag, " busy held"}, 128'(busy), 1);
            step();
            n++;
        end
        check(done == 1'b1, "R8", {tag, " done seen"}, 128'(done), 1);
        check(mem_oe == 1'b0, "R9", {tag, " bus released at done"}, 128'(mem_oe), 0);
        step();
        check(done == 1'b0, "R8", {tag, " done one cycle"}, 128'(done), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        wd_bad = 1;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total + mon_total + 1, bad + mon_bad + wd_bad);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: reset state
        check(!mem_oe && !busy && !done && !dirty, "R1", "idle after reset",
              128'({mem_oe, busy, done, dirty}), 0);
        check(mem_addr == '0 && !fl_wr && !fl_rd && !mem_rd && !mem_wr, "R1", "strobes low",
              128'({mem_addr, fl_wr, fl_rd, mem_rd, mem_wr}), 0);

        // R2: power good, dirty clear, clock-enable toggled: bus stays released
        for (int i = 0; i < 12; i++) begin
            host_cke = i[0];
            step();
            check(!mem_oe && !busy && mem_addr == '0 && mem_wdata == '0, "R2", "released while idle",
                  128'({mem_oe, busy, mem_addr}), 0);
        end
        host_cke = 1'b1;

        // R3 / R4: power loss, host still owns the bus
        fill(1);
        clear_ptrs();
        push_backup(1);
        pwr_good = 1'b0;
        for (int i = 0; i < 8; i++) begin
            step();
            check(mem_oe == 1'b0, "R3", "no drive while cke high", 128'(mem_oe), 0);
        end
        host_cke = 1'b0;
        run_op("backup");
        check(exp_nib_q.size() == 0, "R4", "all nibbles sent", 128'(exp_nib_q.size()), 0);
        check(dirty == 1'b1, "R6", "dirty after backup", 128'(dirty), 1);

        // R10: power still bad, dirty set: no second backup
        for (int i = 0; i < 20; i++) begin
            step();
            check(busy == 1'b0 && !fl_wr, "R10", "no repeated backup", 128'({busy, fl_wr}), 0);
        end

        // R11 / R5: power returns, host holds cke high first
        fill(9);
        clear_ptrs();
        host_cke = 1'b1;
        pwr_good = 1'b1;
        for (int i = 0; i < 6; i++) begin
            step();
            check(mem_oe == 1'b0 && !fl_rd, "R11", "restore waits for cke", 128'({mem_oe, fl_rd}), 0);
        end
        push_restore(1);
        host_cke = 1'b0;
        run_op("restore");
        check(exp_wr_q.size() == 0, "R5", "all words restored", 128'(exp_wr_q.size()), 0);
        check(dirty == 1'b0, "R6", "dirty cleared by restore", 128'(dirty), 0);
        for (int w = 0; w < WORDS; w++)
            check(dram[BASE + w] == pat(1, BASE + w), "R5", "restored content",
                  128'(dram[BASE + w]), 128'(pat(1, BASE + w)));
        check(dram[BASE - 1] == pat(9, BASE - 1), "R5", "below window untouched",
              128'(dram[BASE - 1]), 128'(pat(9, BASE - 1)));
        check(dram[BASE + WORDS] == pat(9, BASE + WORDS), "R5", "above window untouched",
              128'(dram[BASE + WORDS]), 128'(pat(9, BASE + WORDS)));

        // R6: power good with dirty clear: no restore, no flash reads
        for (int i = 0; i < 15; i++) begin
            step();
            check(busy == 1'b0 && !fl_rd && !mem_oe, "R6", "restore skipped when clean",
                  128'({busy, fl_rd, mem_oe}), 0);
        end

        // R7: power returns during a backup
        fill(4);
        clear_ptrs();
        push_backup(4);
        push_restore(4);
        pwr_good = 1'b0;
        repeat (30) step();
        pwr_good = 1'b1;
        run_op("backup-midway");
        check(exp_nib_q.size() == 0, "R7", "backup completed after power return",
              128'(exp_nib_q.size()), 0);
        run_op("restore-after");
        check(exp_wr_q.size() == 0, "R7", "restore followed", 128'(exp_wr_q.size()), 0);
        check(dirty == 1'b0, "R7", "clean after follow-up restore", 128'(dirty), 0);

        repeat (3) step();
        $display("  test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad + wd_bad);
        $finish;
    end
endmodule